// File: doc/BRIEF.md
# Synchronous Memory-Card Bus Monitor

This block listens, without ever driving anything, to the three wires of a synchronous memory-card link: a card reset line, a card clock and a bidirectional data line. All three are brought into the system clock domain through two-flop synchronizers. Edges are found by comparing each synchronized level with its value one system clock earlier. The edge pattern is then turned into bus events, and data bits are packed into bytes.

Each completed byte is reported with a single-cycle strobe, the byte value and a class tag. The tag tells whether the byte is part of the answer to a reset, part of a command, or part of the card's data response. The class is taken from the bus itself. A reset edge selects answer-to-reset. A falling data-line edge while the card clock is high selects command. A rising data-line edge while the card clock is high selects data. A separate single-cycle strobe marks every card reset event.

Top module: `mcm_bus_monitor`

## Requirements
- R1: A rising edge on the synchronized card reset line is a reset event. It pulses `reset_seen` for one cycle, discards the partial byte, clears the bit count and sets the class to answer-to-reset (code 0).
- R2: A data bit is taken on each rising edge of the synchronized card clock, but only while the card reset line is low. Clock edges while reset is high are ignored.
- R3: Bits are packed least significant first. The first bit taken after a clear becomes bit 0 of the byte.
- R4: After the eighth bit, `byte_valid` is high for exactly one cycle, with the byte on `byte_data` and the current class on `byte_class`. The bit count and the partial byte then restart from zero.
- R5: A falling data-line edge while the card clock is high is a command start. It sets the class to command (code 1) and clears the bit count and the partial byte.
- R6: A rising data-line edge while the card clock is high is a command stop. It sets the class to data response (code 2) and clears the bit count and the partial byte.
- R7: When events coincide on one sample, the order of precedence is reset, then data bit, then command start, then command stop. For example, a clock rise together with a data-line fall takes a bit and leaves the class unchanged.
- R8: After system reset, the class is answer-to-reset, the bit count is zero and both strobes are low.
- R9: A partly assembled byte that is interrupted by a reset, start or stop event produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low system reset |
| card_rst | input | 1 | Card reset wire (asynchronous) |
| card_clk | input | 1 | Card clock wire (asynchronous) |
| card_io | input | 1 | Card data wire (asynchronous, observed only) |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte, first bit in bit 0 |
| byte_class | output | 2 | 0 answer-to-reset, 1 command, 2 data |
| reset_seen | output | 1 | One-cycle strobe per card reset event |

## Verification
The first bytes are sent straight after system reset, and then after a card reset that has card clock pulses inside its high phase. This separates the default class from the reset-forced class, and it also shows whether clock edges during reset are wrongly counted. Single-bit patterns such as 0x01 and 0x80, together with asymmetric values, reveal bit-order errors. Start and stop sequences include the clock-high bit they naturally produce, so a missing clear on those events shows up as a shifted byte. Partial bytes cut off by each kind of event, and a clock rise that coincides with a data-line fall, check the dropping rule and the event precedence.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
    typedef enum logic [1:0] {
        CLS_ATR  = 2'd0,
        CLS_CMD  = 2'd1,
        CLS_DATA = 2'd2
    } byte_cls_e;

    localparam int PIN_RST = 0;
    localparam int PIN_CLK = 1;
    localparam int PIN_IO  = 2;
    localparam int NUM_PINS = 3;
endpackage

// File: rtl/mcm_sync.sv
module mcm_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;
    logic [WIDTH-1:0]             prev_d, prev_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        prev_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/mcm_evt.sv
module mcm_evt
    import mcm_pkg::*;
(
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] rise,
    input  logic [NUM_PINS-1:0] fall,
    output logic                ev_rst,
    output logic                ev_bit,
    output logic                ev_start,
    output logic                ev_stop,
    output logic                bit_val
);
    always_comb begin
        ev_rst   = 1'b0;
        ev_bit   = 1'b0;
        ev_start = 1'b0;
        ev_stop  = 1'b0;
        if (rise[PIN_RST]) begin
            ev_rst = 1'b1;
        end else if (!lvl[PIN_RST] && rise[PIN_CLK]) begin
            ev_bit = 1'b1;
        end else if (lvl[PIN_CLK] && fall[PIN_IO]) begin
            ev_start = 1'b1;
        end else if (lvl[PIN_CLK] && rise[PIN_IO]) begin
            ev_stop = 1'b1;
        end
    end

    assign bit_val = lvl[PIN_IO];
endmodule

// File: rtl/mcm_byte_asm.sv
module mcm_byte_asm
    import mcm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rst,
    input  logic              ev_bit,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              bit_val,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output byte_cls_e         byte_class,
    output logic              reset_seen
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] acc;
        byte_cls_e         cls;
        logic              vld;
        logic [DATA_W-1:0] out;
        byte_cls_e         out_cls;
        logic              rst_seen;
    } asm_st_t;

    asm_st_t st_d, st_q;
    logic [DATA_W-1:0] acc_next;

    always_comb begin
        st_d          = st_q;
        st_d.vld      = 1'b0;
        st_d.rst_seen = 1'b0;
        acc_next      = st_q.acc | (DATA_W'(bit_val) << st_q.cnt);
        if (ev_rst) begin
            st_d.cnt      = '0;
            st_d.acc      = '0;
            st_d.cls      = CLS_ATR;
            st_d.rst_seen = 1'b1;
        end else if (ev_bit) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.vld     = 1'b1;
                st_d.out     = acc_next;
                st_d.out_cls = st_q.cls;
                st_d.cnt     = '0;
                st_d.acc     = '0;
            end else begin
                st_d.acc = acc_next;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (ev_start) begin
            st_d.cnt = '0;
            st_d.acc = '0;
            st_d.cls = CLS_CMD;
        end else if (ev_stop) begin
            st_d.cnt = '0;
            st_d.acc = '0;
            st_d.cls = CLS_DATA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, acc: '0, cls: CLS_ATR, vld: 1'b0,
                      out: '0, out_cls: CLS_ATR, rst_seen: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_valid = st_q.vld;
    assign byte_data  = st_q.out;
    assign byte_class = st_q.out_cls;
    assign reset_seen = st_q.rst_seen;

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rst |=> (st_q.cnt == '0) && (st_q.acc == '0) && (st_q.cls == CLS_ATR) && reset_seen);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_rst || ev_bit || ev_start || ev_stop) |=> $stable(st_q.cnt) && $stable(st_q.acc));

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (st_q.cnt == '0) && (st_q.acc == '0));

    assert_start_sets_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_rst && !ev_bit) |=> (st_q.cls == CLS_CMD) && (st_q.cnt == '0));

    assert_stop_sets_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_rst && !ev_bit && !ev_start) |=> (st_q.cls == CLS_DATA) && (st_q.cnt == '0));

    assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && reset_seen));
endmodule

// File: rtl/mcm_bus_monitor.sv
module mcm_bus_monitor
    import mcm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_rst,
    input  logic              card_clk,
    input  logic              card_io,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic [1:0]        byte_class,
    output logic              reset_seen
);
    logic [NUM_PINS-1:0] pins_raw, pins_lvl, pins_rise, pins_fall;
    logic ev_rst, ev_bit, ev_start, ev_stop, bit_val;
    byte_cls_e cls_out;

    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_RST] = card_rst;
        pins_raw[PIN_CLK] = card_clk;
        pins_raw[PIN_IO]  = card_io;
    end

    mcm_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .lvl  (pins_lvl),
        .rise (pins_rise),
        .fall (pins_fall)
    );

    mcm_evt u_evt (
        .lvl     (pins_lvl),
        .rise    (pins_rise),
        .fall    (pins_fall),
        .ev_rst  (ev_rst),
        .ev_bit  (ev_bit),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .bit_val (bit_val)
    );

    mcm_byte_asm #(.DATA_W(DATA_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_rst    (ev_rst),
        .ev_bit    (ev_bit),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .bit_val   (bit_val),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .byte_class(cls_out),
        .reset_seen(reset_seen)
    );

    assign byte_class = cls_out;

    assert_bit_blocked_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pins_lvl[PIN_RST] |-> !ev_bit);
endmodule

// File: tb/mcm_bus_monitor_tb.sv
module mcm_bus_monitor_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 1'b0;
    logic card_clk = 1'b0;
    logic card_io = 1'b1;
    logic byte_valid, reset_seen;
    logic [7:0] byte_data;
    logic [1:0] byte_class;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_rst;
        logic [1:0] cls;
        logic [7:0] data;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    mcm_bus_monitor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .card_rst  (card_rst),
        .card_clk  (card_clk),
        .card_io   (card_io),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .byte_class(byte_class),
        .reset_seen(reset_seen)
    );

    task automatic step();
        repeat (4) @(negedge clk);
    endtask

    task automatic push_byte(input logic [1:0] c, input logic [7:0] d, input string r);
        exp_t e;
        e.is_rst = 1'b0; e.cls = c; e.data = d; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic push_rst(input string r);
        exp_t e;
        e.is_rst = 1'b1; e.cls = 2'd0; e.data = 8'h00; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic send_bit(input logic b);
        card_io = b;  step();
        card_clk = 1; step();
        card_clk = 0; step();
    endtask

    task automatic send_bits(input logic [7:0] v, input int first, input int n);
        for (int i = first; i < first + n; i++) send_bit(v[i]);
    endtask

    task automatic card_reset();
        card_rst = 1; step();
        card_clk = 1; step();   // R2: clock pulse while reset high is ignored
        card_clk = 0; step();
        card_rst = 0; step();
    endtask

    task automatic cmd_start();
        card_io = 1;  step();
        card_clk = 1; step();
        card_io = 0;  step();
        card_clk = 0; step();
    endtask

    task automatic cmd_stop();
        card_io = 0;  step();
        card_clk = 1; step();
        card_io = 1;  step();
        card_clk = 0; step();
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reset_seen || byte_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R9: unexpected output valid=%0b rst=%0b data=%02h cls=%0d, expected none",
                             byte_valid, reset_seen, byte_data, byte_class);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_rst) begin
                        if (!reset_seen || byte_valid) begin
                            fails++;
                            $display("FAIL %s: got valid=%0b rst=%0b, expected reset strobe", e.req,
                                     byte_valid, reset_seen);
                        end
                    end else if (!byte_valid || byte_data !== e.data || byte_class !== e.cls) begin
                        fails++;
                        $display("FAIL %s: got valid=%0b data=%02h cls=%0d, expected data=%02h cls=%0d",
                                 e.req, byte_valid, byte_data, byte_class, e.data, e.cls);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (byte_valid !== 1'b0 || reset_seen !== 1'b0) begin
            fails++;
            $display("FAIL R8: strobes valid=%0b rst=%0b, expected 0 0", byte_valid, reset_seen);
        end
        rst_n = 1'b1;
        step();
        checks++;
        if (byte_valid !== 1'b0 || reset_seen !== 1'b0) begin
            fails++;
            $display("FAIL R8: idle strobes valid=%0b rst=%0b, expected 0 0", byte_valid, reset_seen);
        end

        // R8: default class after system reset is answer-to-reset
        push_byte(2'd0, 8'h3C, "R8");
        send_bits(8'h3C, 0, 8);

        // R1/R2: card reset with clock pulse inside; then ATR bytes, R3 bit order
        push_rst("R1");
        card_reset();
        push_byte(2'd0, 8'hA5, "R2");
        send_bits(8'hA5, 0, 8);
        push_byte(2'd0, 8'h01, "R3");
        send_bits(8'h01, 0, 8);
        push_byte(2'd0, 8'h80, "R3");
        send_bits(8'h80, 0, 8);

        // R5: command start then command bytes
        cmd_start();
        push_byte(2'd1, 8'h30, "R5");
        send_bits(8'h30, 0, 8);
        push_byte(2'd1, 8'h5A, "R4");
        send_bits(8'h5A, 0, 8);

        // R6: command stop then data bytes
        cmd_stop();
        push_byte(2'd2, 8'hF0, "R6");
        send_bits(8'hF0, 0, 8);
        push_byte(2'd2, 8'h81, "R6");
        send_bits(8'h81, 0, 8);

        // R9: partial byte dropped by reset
        send_bits(8'hFF, 0, 3);
        push_rst("R9");
        card_reset();
        push_byte(2'd0, 8'h11, "R9");
        send_bits(8'h11, 0, 8);

        // R9: partial byte dropped by start
        send_bits(8'hFF, 0, 5);
        cmd_start();
        push_byte(2'd1, 8'h44, "R9");
        send_bits(8'h44, 0, 8);

        // R9: partial byte dropped by stop
        send_bits(8'h00, 0, 6);
        cmd_stop();
        push_byte(2'd2, 8'h2B, "R9");
        send_bits(8'h2B, 0, 8);

        // R7: clock rise together with data-line fall takes a bit, class stays data
        card_io = 1; step();
        card_io = 0; card_clk = 1; step();
        card_clk = 0; step();
        push_byte(2'd2, 8'hC6, "R7");
        send_bits(8'hC6, 1, 7);

        step(); step();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R4: %0d expected outputs missing, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule